// File: doc/BRIEF.md
# IR Carrier Burst Timer

This block shapes the mark and space segments of an infrared remote-control transmission. Software writes one timer word holding a carrier-enable flag and a segment count. The block then counts that segment down on a machine-cycle tick supplied by the surrounding core. While the segment is live and the flag is set, it gates a free-running divided-clock carrier onto the transmit output and pulls a transmit-activity indicator low.

The carrier period is either the base divisor (8 clocks) or the alternate divisor (12 clocks). With the alternate divisor, a strap input picks a half or a one-third high time. When the count first reads zero, a one-cycle done pulse is raised so that a halted core can wake and write the next segment. A write made in the cycle after that pulse continues the burst with no break in the carrier.

Top module: `ir_burst_timer`

## Requirements
- R1: On reset, and afterwards until a timer word is written, carrier_o is 0, busy_n_o is 1 and done_o is 0. A reset during a burst ends it.
- R2: A write of load_word_i takes bit 9 as the carrier enable and bits 8:0 as the count V. With bit 9 set, busy_n_o falls in the cycle after the write edge.
- R3: The count drops by one on each tick edge after the write while run_i is 1. done_o is high for exactly one cycle, in the cycle the count first reads zero. For V = 0 that is the cycle after the write edge.
- R4: A segment ends on the (V+1)-th tick edge after the write, so it lasts (V+1) × 8 clocks when the write is tick-aligned. busy_n_o rises one cycle after that edge.
- R5: While run_i is 0, the count and the segment are frozen. No done pulse occurs and the indicator stays low. Counting resumes with the next tick once run_i returns to 1.
- R6: With the enable bit 0, the segment still counts and raises done_o, but carrier_o stays 0 and busy_n_o stays 1.
- R7: With div_sel_i = 0 the carrier has a period of 8 clocks and is high for 4 of them.
- R8: With div_sel_i = 1 and duty_third_i = 0 the carrier has a period of 12 clocks and is high for 6 of them.
- R9: With div_sel_i = 1 and duty_third_i = 1 the carrier has a period of 12 clocks and is high for 4 of them.
- R10: A write in the cycle after done_o keeps busy_n_o low and every carrier pulse full-length across the joint. The new segment counts from that write.
- R11: carrier_o is never 1 while busy_n_o is 1. The carrier divider runs freely, so the first and last pulses of a burst may be shortened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Machine-cycle tick, one clock in every 8 |
| run_i | input | 1 | Counting enabled when 1 |
| div_sel_i | input | 1 | Carrier divisor: 0 selects 8, 1 selects 12 |
| duty_third_i | input | 1 | Strap for the 12-clock carrier: 0 half duty, 1 one-third duty |
| load_i | input | 1 | Writes load_word_i into the timer this cycle |
| load_word_i | input | 10 | Bit 9 carrier enable, bits 8:0 count |
| carrier_o | output | 1 | Transmit carrier output |
| busy_n_o | output | 1 | Transmit activity indicator, low while the carrier is emitted |
| done_o | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
Every result has a fixed latency from its cause. busy_n_o falls one clock after the write edge. done_o appears in the cycle after the V-th tick edge that follows the write. busy_n_o rises one clock after the (V+1)-th tick edge, because the segment state and the output register each add one stage. The bench generates the tick itself on every eighth edge and drives all inputs on falling edges. It computes these cycle numbers from the write edge and the tick positions, and queues them in cycle order. A monitor samples on each falling edge and compares every done pulse and indicator edge against the front of that queue. Carrier high times and periods are counted in falling-edge samples once the burst has settled, so they do not depend on the phase of the divider.

// File: rtl/ir_burst_pkg.sv
package ir_burst_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // Carrier period in clocks for the selected divisor.
  function automatic int unsigned car_period(input logic alt_sel,
                                             input int unsigned base_div,
                                             input int unsigned alt_div);
    return alt_sel ? alt_div : base_div;
  endfunction

  // Number of high clocks within one carrier period.
  function automatic int unsigned car_high(input logic alt_sel,
                                           input logic third,
                                           input int unsigned base_div,
                                           input int unsigned alt_div);
    if (!alt_sel) return base_div / 2;
    return third ? (alt_div / 3) : (alt_div / 2);
  endfunction
endpackage

// File: rtl/ir_car_div.sv
module ir_car_div
  import ir_burst_pkg::*;
#(
  parameter int unsigned BASE_DIV = 8,
  parameter int unsigned ALT_DIV  = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic alt_sel_i,
  input  logic third_i,
  output logic car_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned MAX_DIV = (ALT_DIV > BASE_DIV) ? ALT_DIV : BASE_DIV;
  localparam int unsigned PH_W    = $clog2(MAX_DIV);

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] last_ph;
  logic [PH_W-1:0] high_lim;
  logic            phase_wrap;

  always_comb begin
    last_ph  = PH_W'(car_period(alt_sel_i, BASE_DIV, ALT_DIV) - 1);
    high_lim = PH_W'(car_high(alt_sel_i, third_i, BASE_DIV, ALT_DIV));
  end

  // Free-running: never restarted by a segment write.
  assign phase_wrap = (phase_q >= last_ph);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         phase_q <= '0;
    else if (phase_wrap) phase_q <= '0;
    else                 phase_q <= phase_q + PH_W'(1);
  end

  assign car_o = (phase_q < high_lim);

  AST_PHASE_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == last_ph) |=> (phase_q == '0)); // R7

  AST_PHASE_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q < last_ph) |=> (phase_q == $past(phase_q) + PH_W'(1))); // R8
endmodule

// File: rtl/ir_seg_counter.sv
module ir_seg_counter #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [CNT_W:0]   load_word_i,
  output logic             emit_o,
  output logic             done_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [CNT_W-1:0] cnt_q;
  logic             en_q;
  logic             active_q;
  logic             done_q;

  logic step;
  logic cnt_zero;
  logic seg_expire;
  logic cnt_dec;
  logic hit_zero;

  assign step       = run_i & tick_i & active_q & ~load_i;
  assign cnt_zero   = (cnt_q == '0);
  assign seg_expire = step & cnt_zero;
  assign cnt_dec    = step & ~cnt_zero;
  assign hit_zero   = (cnt_dec & (cnt_q == CNT_W'(1))) |
                      (load_i & (load_word_i[CNT_W-1:0] == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      en_q     <= 1'b0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= hit_zero;
      if (load_i) begin
        cnt_q    <= load_word_i[CNT_W-1:0];
        en_q     <= load_word_i[CNT_W];
        active_q <= 1'b1;
      end else if (seg_expire) begin
        active_q <= 1'b0;
      end else if (cnt_dec) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign emit_o = en_q & active_q;
  assign done_o = done_q;

  AST_STEP_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_dec |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R3

  AST_DONE_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (cnt_q == '0) && active_q); // R3

  AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> ($stable(cnt_q) && $stable(active_q) && !done_q)); // R5

  AST_EXPIRE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_expire |=> !active_q); // R4
endmodule

// File: rtl/ir_tx_gate.sv
module ir_tx_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic emit_i,
  input  logic car_i,
  output logic carrier_o,
  output logic busy_n_o
);
  timeunit 1ns;
  timeprecision 1ps;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carrier_o <= 1'b0;
      busy_n_o  <= 1'b1;
    end else begin
      carrier_o <= emit_i & car_i;
      busy_n_o  <= ~emit_i;
    end
  end

  AST_SILENT_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !emit_i |=> (!carrier_o && busy_n_o)); // R6

  AST_CARRIER_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carrier_o |-> !busy_n_o); // R11
endmodule

// File: rtl/ir_burst_timer.sv
module ir_burst_timer #(
  parameter int unsigned CNT_W    = 9,
  parameter int unsigned BASE_DIV = 8,
  parameter int unsigned ALT_DIV  = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           run_i,
  input  logic           div_sel_i,
  input  logic           duty_third_i,
  input  logic           load_i,
  input  logic [CNT_W:0] load_word_i,
  output logic           carrier_o,
  output logic           busy_n_o,
  output logic           done_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic seg_emit;
  logic car_raw;

  ir_seg_counter #(.CNT_W(CNT_W)) u_seg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .run_i       (run_i),
    .load_i      (load_i),
    .load_word_i (load_word_i),
    .emit_o      (seg_emit),
    .done_o      (done_o)
  );

  ir_car_div #(.BASE_DIV(BASE_DIV), .ALT_DIV(ALT_DIV)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .alt_sel_i (div_sel_i),
    .third_i   (duty_third_i),
    .car_o     (car_raw)
  );

  ir_tx_gate u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .emit_i    (seg_emit),
    .car_i     (car_raw),
    .carrier_o (carrier_o),
    .busy_n_o  (busy_n_o)
  );

  AST_LOAD_STARTS_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_word_i[CNT_W]) |=> seg_emit); // R2
endmodule

// File: tb/ir_burst_timer_tb_top.sv
module ir_burst_timer_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CNT_W = 9;
  localparam int TICK  = 8;
  localparam int LIMIT = 20000;

  typedef enum int {EV_DONE, EV_FALL, EV_RISE} ev_kind_t;
  typedef struct {
    ev_kind_t kind;
    int       cyc;
    string    req;
  } ev_t;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           tick = 1'b0;
  logic           run = 1'b0;
  logic           div_sel = 1'b0;
  logic           duty_third = 1'b0;
  logic           load = 1'b0;
  logic [CNT_W:0] word = '0;
  logic           carrier, busy_n, done;

  int  cyc = 0;
  int  n_checks = 0;
  int  n_errs = 0;
  bit  mon_en = 1'b0;
  logic prev_busy = 1'b1;
  ev_t exp_q[$];

  always #4 clk = ~clk; // 125 MHz

  ir_burst_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .run_i(run),
    .div_sel_i(div_sel), .duty_third_i(duty_third), .load_i(load),
    .load_word_i(word), .carrier_o(carrier), .busy_n_o(busy_n), .done_o(done)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Tick on every edge whose number is a multiple of TICK.
  initial forever begin
    @(negedge clk);
    tick <= ((cyc + 1) % TICK == 0);
  end

  function automatic int nt(int base, int k);
    return ((base / TICK) + k) * TICK;
  endfunction

  task automatic check(bit ok, string req, int act, int exp, string what);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push_ev(ev_kind_t k, int c, string req);
    ev_t e;
    int  i;
    e.kind = k; e.cyc = c; e.req = req;
    i = 0;
    while (i < exp_q.size() && exp_q[i].cyc <= c) i++;
    exp_q.insert(i, e);
  endtask

  task automatic take(ev_kind_t k);
    ev_t e;
    n_checks++;
    if (exp_q.size() == 0) begin
      n_errs++;
      $display("FAIL %s unexpected %s: actual=cycle %0d expected=none",
               (k == EV_DONE) ? "R3" : "R4", k.name(), cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != k || e.cyc != cyc) begin
        n_errs++;
        $display("FAIL %s event: actual=%s@%0d expected=%s@%0d",
                 e.req, k.name(), cyc, e.kind.name(), e.cyc);
      end
    end
  endtask

  // Monitor: pops the scoreboard as done pulses and indicator edges appear.
  always @(negedge clk) begin
    if (mon_en) begin
      if (done === 1'b1) take(EV_DONE);
      if (busy_n !== prev_busy) take(busy_n ? EV_RISE : EV_FALL);
    end
    prev_busy = busy_n;
  end

  always @(posedge clk) begin
    if (cyc == LIMIT) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual=cycle %0d expected=finish earlier", cyc);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  task automatic to_tick_edge();
    @(negedge clk);
    while ((cyc + 1) % TICK != 0) @(negedge clk);
  endtask

  task automatic measure(int n, int hi_exp, int per_exp, string req);
    int guard;
    guard = 0;
    while (carrier !== 1'b0 && guard < 100) begin @(negedge clk); guard++; end
    while (carrier !== 1'b1 && guard < 200) begin @(negedge clk); guard++; end
    for (int k = 0; k < n; k++) begin
      int hi;
      int lo;
      hi = 0; lo = 0;
      check(busy_n === 1'b0, "R11", busy_n, 0, "indicator while carrier high");
      while (carrier === 1'b1 && hi < 100) begin hi++; @(negedge clk); end
      while (carrier === 1'b0 && lo < 100) begin lo++; @(negedge clk); end
      check(hi == hi_exp, req, hi, hi_exp, "carrier high clocks");
      check(hi + lo == per_exp, req, hi + lo, per_exp, "carrier period");
    end
  endtask

  // One tick-aligned segment with its expected events queued in advance.
  task automatic run_seg(int v, bit en, int hi_exp, int per_exp, string mreq);
    int pl;
    int endc;
    int stray;
    to_tick_edge();
    pl   = cyc + 1;
    endc = nt(pl, v + 1);
    push_ev(EV_DONE, (v == 0) ? pl : nt(pl, v), "R3");
    if (en) begin
      push_ev(EV_FALL, pl + 1, "R2");
      push_ev(EV_RISE, endc + 1, "R4");
    end
    load = 1'b1;
    word = {en, CNT_W'(v)};
    @(negedge clk);
    load = 1'b0;
    if (per_exp > 0) begin
      repeat (24) @(negedge clk);
      measure(3, hi_exp, per_exp, mreq);
    end
    stray = 0;
    while (cyc < endc + 3) begin
      @(negedge clk);
      if (!en && (carrier !== 1'b0 || busy_n !== 1'b1)) stray++;
    end
    if (!en) check(stray == 0, "R6", stray, 0, "carrier or indicator activity");
    check(exp_q.size() == 0, "R4", exp_q.size(), 0, "pending events");
  endtask

  initial begin
    int pl;
    int pd;
    int pr;
    int stray;

    // R1: reset state
    repeat (4) @(negedge clk);
    check(carrier === 1'b0, "R1", carrier, 0, "carrier in reset");
    check(busy_n === 1'b1, "R1", busy_n, 1, "indicator in reset");
    check(done === 1'b0, "R1", done, 0, "done in reset");
    rst_n = 1'b1;
    run = 1'b1;
    repeat (2) @(negedge clk);
    @(posedge clk);
    mon_en = 1'b1;
    repeat (30) @(negedge clk);
    check(carrier === 1'b0, "R1", carrier, 0, "carrier idle after reset");
    check(busy_n === 1'b1, "R1", busy_n, 1, "indicator idle after reset");

    // R7, R8, R9: divisor and duty modes
    run_seg(40, 1'b1, 4, 8, "R7");
    div_sel = 1'b1; duty_third = 1'b0;
    run_seg(30, 1'b1, 6, 12, "R8");
    duty_third = 1'b1;
    run_seg(30, 1'b1, 4, 12, "R9");
    div_sel = 1'b0; duty_third = 1'b0;

    // R3: zero count
    run_seg(0, 1'b1, 0, 0, "R3");
    // R6: carrier disabled
    run_seg(5, 1'b0, 0, 0, "R6");

    // R5: stopped counter
    run = 1'b0;
    to_tick_edge();
    pl = cyc + 1;
    push_ev(EV_FALL, pl + 1, "R2");
    load = 1'b1; word = {1'b1, CNT_W'(3)};
    @(negedge clk);
    load = 1'b0;
    repeat (40) @(negedge clk);
    check(busy_n === 1'b0, "R5", busy_n, 0, "indicator while stopped");
    check(exp_q.size() == 0, "R5", exp_q.size(), 0, "events while stopped");
    to_tick_edge();
    pr = cyc + 1;
    push_ev(EV_DONE, nt(pr - 1, 3), "R5");
    push_ev(EV_RISE, nt(pr - 1, 4) + 1, "R5");
    run = 1'b1;
    while (cyc < nt(pr - 1, 4) + 4) @(negedge clk);
    check(exp_q.size() == 0, "R5", exp_q.size(), 0, "pending events after resume");

    // R10: seamless reload right after done
    to_tick_edge();
    pl = cyc + 1;
    pd = nt(pl, 6);
    push_ev(EV_FALL, pl + 1, "R2");
    push_ev(EV_DONE, pd, "R3");
    load = 1'b1; word = {1'b1, CNT_W'(6)};
    @(negedge clk);
    load = 1'b0;
    fork
      begin
        while (cyc < pd - 14) @(negedge clk);
        measure(5, 4, 8, "R10");
      end
      begin
        while (cyc < pd) @(negedge clk);
        push_ev(EV_DONE, nt(pd + 1, 5), "R10");
        push_ev(EV_RISE, nt(pd + 1, 6) + 1, "R10");
        load = 1'b1; word = {1'b1, CNT_W'(5)};
        @(negedge clk);
        load = 1'b0;
      end
    join
    while (cyc < nt(pd + 1, 6) + 4) @(negedge clk);
    check(exp_q.size() == 0, "R10", exp_q.size(), 0, "pending events after reload");

    // R1: reset in the middle of a burst
    to_tick_edge();
    pl = cyc + 1;
    push_ev(EV_FALL, pl + 1, "R2");
    load = 1'b1; word = {1'b1, CNT_W'(50)};
    @(negedge clk);
    load = 1'b0;
    repeat (30) @(negedge clk);
    @(posedge clk);
    mon_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    exp_q.delete();
    repeat (3) @(negedge clk);
    check(carrier === 1'b0, "R1", carrier, 0, "carrier after mid-burst reset");
    check(busy_n === 1'b1, "R1", busy_n, 1, "indicator after mid-burst reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    @(posedge clk);
    mon_en = 1'b1;
    stray = 0;
    repeat (80) begin
      @(negedge clk);
      if (busy_n !== 1'b1 || carrier !== 1'b0) stray++;
    end
    check(stray == 0, "R1", stray, 0, "activity after reset without write");

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule